// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sleep and Wakeup

This block recovers characters from one asynchronous serial line. The line is sampled on a strobe that pulses sixteen times per bit period. A falling edge starts a character. Every bit, the start bit included, is resolved by a majority vote over the three samples around its centre. At run time the character format is either one start bit, eight data bits and one stop bit, or one start bit, nine data bits and one stop bit. The low eight data bits go to a byte output. In nine-bit mode the last data bit goes to a separate bit output.

Software can put the receiver to sleep, for example to skip traffic meant for other stations on a shared line. While asleep, the receiver keeps framing characters but does not touch its data outputs or its receive-side flags. It leaves sleep in one of two ways, chosen by an input:
- on a line that stays idle for a full character time, or
- on a character whose most significant data bit is 1 (an address mark); that character is delivered normally.

The block reports these flags:
- data-full, overrun and idle;
- noise and framing status for the most recent accepted character.

A single interrupt request combines the flags, gated by two enable inputs.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, every output is 0: rx_data, rx_bit8, data_full, overrun, idle_seen, noise_seen, frame_err, asleep and irq.
- R2: With nine_bit=0, a character is 1 start bit (0), then 8 data bits sent least significant bit first, then 1 stop bit (1). On completion, rx_data holds the 8 bits, rx_bit8 is 0 and data_full is 1.
- R3: With nine_bit=1, the character carries 9 data bits, least significant bit first. rx_data holds data bits 0..7 and rx_bit8 holds data bit 8.
- R4: Each bit is decided by a majority of samples 7, 8 and 9 out of 16. When one of these three samples disagrees with the other two, the bit value still follows the majority and noise_seen is set for that character. A low pulse shorter than half a bit period produces no character.
- R5: When the stop bit resolves to 0, frame_err is 1 for that character. It is 0 for a character whose stop bit resolves to 1.
- R6: When a character completes while data_full is still 1 (and no rd_ack pulse arrives in that cycle), overrun becomes 1 and rx_data keeps the earlier byte. A one-cycle rd_ack pulse clears data_full, overrun and idle_seen.
- R7: idle_seen becomes 1 after the line has stayed high for one character time (10 bit periods with nine_bit=0, 11 with nine_bit=1), provided that at least one character has been framed since the last idle detection. The idle detector stays disarmed from reset until the first character.
- R8: A sleep_req pulse sets asleep. While asleep, characters do not change rx_data, rx_bit8, data_full or overrun. With wake_on_mark=1, a character whose most significant data bit is 1 (bit 8 in nine-bit mode, bit 7 otherwise) clears asleep and is delivered like a normal character.
- R9: With wake_on_mark=0, an idle detection while asleep clears asleep without setting idle_seen. The next character is delivered normally.
- R10: irq is 1 exactly when (rx_irq_en and (data_full or overrun)) or (idle_irq_en and idle_seen).
- R11: While rx_en is 0, the line is ignored. Dropping rx_en also clears asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe, 16 per bit period |
| line_in | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_on_mark | input | 1 | Wake condition: 1 = address mark, 0 = idle line |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rd_ack | input | 1 | Pulse marking that the data was read |
| rx_irq_en | input | 1 | Enables the interrupt from data-full and overrun |
| idle_irq_en | input | 1 | Enables the interrupt from idle |
| rx_data | output | 8 | Received data byte |
| rx_bit8 | output | 1 | Ninth data bit in nine-bit mode |
| data_full | output | 1 | Unread character present |
| overrun | output | 1 | A character was lost |
| idle_seen | output | 1 | Idle line detected |
| noise_seen | output | 1 | Sample disagreement in the last accepted character |
| frame_err | output | 1 | Stop bit of the last accepted character was 0 |
| asleep | output | 1 | Receiver is asleep |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: 16 samples per bit and a two-flop synchronizer. It pulses the strobe every fourth clock, so one bit period lasts 64 clocks. At this spacing a four-clock glitch lands on exactly one of the three voting samples, which makes the noise vote testable. The same spacing keeps idle gaps of 10 and 11 bit periods, in both formats and in both wakeup modes, short enough for many random characters to fit in one run.

// File: rtl/uwr_pkg.sv
// Shared types for the oversampled serial receiver.
// Assumes: one character is at most 9 data bits.
package uwr_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_t;

    // One framed character as handed from the framer to the status logic.
    typedef struct packed {
        logic [7:0] data;
        logic       ninth;
        logic       mark;
        logic       frame_bad;
        logic       noisy;
    } rx_char_t;

endpackage

// File: rtl/uwr_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Assumes: the line idles high, so every stage resets to 1.
module uwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/uwr_framer.sv
// Character framer: finds the start edge, votes each bit from the three
// samples around its centre, and assembles the data bits (LSB first).
// Assumes: OVS is a power of two of at least 8; tick is one cycle wide.
module uwr_framer
    import uwr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     tick,
    input  logic     line,
    input  logic     nine,
    output logic     done,
    output rx_char_t chr
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam logic [CW-1:0] S_A   = CW'(MID - 1);
    localparam logic [CW-1:0] S_B   = CW'(MID);
    localparam logic [CW-1:0] S_C   = CW'(MID + 1);
    localparam logic [CW-1:0] S_END = CW'(OVS - 1);

    fr_state_t   state;
    logic [CW-1:0] cnt;
    logic [3:0]  idx;
    logic [8:0]  sh;
    logic        smp_a, smp_b;
    logic        noisy_acc;
    logic        nine_q;
    logic        vote, disagree;
    logic [3:0]  last_idx;

    // Majority of the three centre samples, and whether they differ.
    always_comb begin
        vote     = (smp_a & smp_b) | (smp_a & line) | (smp_b & line);
        disagree = !((smp_a == smp_b) && (smp_b == line));
        last_idx = nine_q ? 4'd9 : 4'd8;
    end

    // Framing state machine, advanced on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FR_IDLE;
            cnt       <= '0;
            idx       <= '0;
            sh        <= '0;
            smp_a     <= 1'b1;
            smp_b     <= 1'b1;
            noisy_acc <= 1'b0;
            nine_q    <= 1'b0;
            done      <= 1'b0;
            chr       <= '0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                state <= FR_IDLE;
                cnt   <= '0;
            end else if (tick) begin
                if (state == FR_IDLE) begin
                    if (!line) begin
                        state     <= FR_START;
                        cnt       <= CW'(1);
                        idx       <= '0;
                        noisy_acc <= 1'b0;
                        nine_q    <= nine;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                    if (cnt == S_A) smp_a <= line;
                    if (cnt == S_B) smp_b <= line;
                    if (cnt == S_C) begin
                        noisy_acc <= noisy_acc | disagree;
                        case (state)
                            FR_START: if (vote) state <= FR_IDLE;
                            FR_DATA: begin
                                sh  <= {vote, sh[8:1]};
                                idx <= idx + 4'd1;
                            end
                            FR_STOP: begin
                                state         <= FR_IDLE;
                                done          <= 1'b1;
                                chr.data      <= nine_q ? sh[7:0] : sh[8:1];
                                chr.ninth     <= nine_q & sh[8];
                                chr.mark      <= sh[8];
                                chr.frame_bad <= !vote;
                                chr.noisy     <= noisy_acc | disagree;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == S_END) begin
                        if (state == FR_START)
                            state <= FR_DATA;
                        else if (state == FR_DATA && idx == last_idx)
                            state <= FR_STOP;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uwr_idle_det.sv
// Idle-line detector: counts strobes while the line is high and fires one
// pulse when a full character time has passed, once per framed character.
// Assumes: char_done is a one-cycle pulse from the framer.
module uwr_idle_det #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic line,
    input  logic nine,
    input  logic char_done,
    output logic hit
);
    localparam int LONG_T = 11 * OVS;
    localparam int SHORT_T = 10 * OVS;
    localparam int IW = $clog2(LONG_T + 1);

    logic [IW-1:0] run;
    logic [IW-1:0] lim;
    logic          armed;

    // Idle threshold follows the current character format.
    always_comb lim = nine ? IW'(LONG_T) : IW'(SHORT_T);

    // Count strobes of continuous high line, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)             run <= '0;
        else if (!enable)       run <= '0;
        else if (tick) begin
            if (!line)          run <= '0;
            else if (run < lim) run <= run + 1'b1;
        end
    end

    // Arm on each framed character; fire once and disarm on a long high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            hit   <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (!enable) begin
                armed <= 1'b0;
            end else if (char_done) begin
                armed <= 1'b1;
            end else if (armed && line && run >= lim) begin
                armed <= 1'b0;
                hit   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uwr_status.sv
// Status and wakeup logic: holds the data registers and flags, manages the
// sleep state and forms the combined interrupt request.
// Assumes: char_done and idle_hit are one-cycle pulses.
module uwr_status
    import uwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       wake_sel,
    input  logic       sleep_req,
    input  logic       rd_ack,
    input  logic       char_done,
    input  rx_char_t   chr,
    input  logic       idle_hit,
    input  logic       rx_irq_en,
    input  logic       idle_irq_en,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       data_full,
    output logic       overrun,
    output logic       idle_seen,
    output logic       noise_seen,
    output logic       frame_err,
    output logic       asleep,
    output logic       irq
);
    logic mark_wake, idle_wake, accept, full_left;

    // Decide whether this cycle's events wake the receiver or deliver data.
    always_comb begin
        mark_wake = asleep && wake_sel && char_done && chr.mark;
        idle_wake = asleep && !wake_sel && idle_hit;
        accept    = char_done && (!asleep || mark_wake);
        full_left = data_full && !rd_ack;
    end

    // Sleep state: set on request, cleared by wakeup or by disabling.
    always_ff @(posedge clk) begin
        if (!rst_n)                      asleep <= 1'b0;
        else if (!enable)                asleep <= 1'b0;
        else if (mark_wake || idle_wake) asleep <= 1'b0;
        else if (sleep_req)              asleep <= 1'b1;
    end

    // Data registers and receive flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_bit8    <= 1'b0;
            data_full  <= 1'b0;
            overrun    <= 1'b0;
            idle_seen  <= 1'b0;
            noise_seen <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            if (rd_ack) begin
                data_full <= 1'b0;
                overrun   <= 1'b0;
                idle_seen <= 1'b0;
            end
            if (accept) begin
                if (full_left) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data    <= chr.data;
                    rx_bit8    <= chr.ninth;
                    data_full  <= 1'b1;
                    noise_seen <= chr.noisy;
                    frame_err  <= chr.frame_bad;
                end
            end
            if (idle_hit && !asleep) idle_seen <= 1'b1;
        end
    end

    // Combined interrupt request from the enabled sources.
    always_comb irq = (rx_irq_en && (data_full || overrun)) ||
                      (idle_irq_en && idle_seen);
endmodule

// File: rtl/uart_wake_rx.sv
// Top of the oversampled serial receiver with sleep and wakeup.
// Assumes: tick16 pulses OVS times per bit period; the control inputs
// are synchronous to clk; line_in is asynchronous.
module uart_wake_rx
    import uwr_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       line_in,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       wake_on_mark,
    input  logic       sleep_req,
    input  logic       rd_ack,
    input  logic       rx_irq_en,
    input  logic       idle_irq_en,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       data_full,
    output logic       overrun,
    output logic       idle_seen,
    output logic       noise_seen,
    output logic       frame_err,
    output logic       asleep,
    output logic       irq
);
    logic     line_s;
    logic     char_done;
    rx_char_t chr;
    logic     idle_hit;

    uwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_in),
        .q_sync  (line_s)
    );

    uwr_framer #(.OVS(OVS)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rx_en),
        .tick   (tick16),
        .line   (line_s),
        .nine   (nine_bit),
        .done   (char_done),
        .chr    (chr)
    );

    uwr_idle_det #(.OVS(OVS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en),
        .tick      (tick16),
        .line      (line_s),
        .nine      (nine_bit),
        .char_done (char_done),
        .hit       (idle_hit)
    );

    uwr_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (rx_en),
        .wake_sel    (wake_on_mark),
        .sleep_req   (sleep_req),
        .rd_ack      (rd_ack),
        .char_done   (char_done),
        .chr         (chr),
        .idle_hit    (idle_hit),
        .rx_irq_en   (rx_irq_en),
        .idle_irq_en (idle_irq_en),
        .rx_data     (rx_data),
        .rx_bit8     (rx_bit8),
        .data_full   (data_full),
        .overrun     (overrun),
        .idle_seen   (idle_seen),
        .noise_seen  (noise_seen),
        .frame_err   (frame_err),
        .asleep      (asleep),
        .irq         (irq)
    );
endmodule

// File: rtl/uwr_checker.sv
// Temporal checks on the receiver, attached to the top through bind.
module uwr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_ack,
    input logic       wake_on_mark,
    input logic       char_done,
    input logic       char_mark,
    input logic       asleep,
    input logic       data_full,
    input logic       overrun,
    input logic       idle_seen,
    input logic [7:0] rx_data,
    input logic       irq
);
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !char_done) |=> (!data_full && !overrun));

    p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_full && !rd_ack && char_done && !asleep) |=> (overrun && $stable(rx_data)));

    p_sleep_holds_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !(char_done && wake_on_mark && char_mark)) |=> $stable(rx_data));

    p_sleep_no_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> !$rose(idle_seen));

    p_disable_gates_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!char_done && !asleep));

    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (data_full || overrun || idle_seen));
endmodule

bind uart_wake_rx uwr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .rd_ack       (rd_ack),
    .wake_on_mark (wake_on_mark),
    .char_done    (char_done),
    .char_mark    (chr.mark),
    .asleep       (asleep),
    .data_full    (data_full),
    .overrun      (overrun),
    .idle_seen    (idle_seen),
    .rx_data      (rx_data),
    .irq          (irq)
);

// File: tb/sim_uart_wake_rx.sv
module sim_uart_wake_rx;
    localparam int BITCLK = 64;   // 16 strobes, one every 4 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic line_in = 1'b1;
    logic rx_en = 1'b0, nine_bit = 1'b0, wake_on_mark = 1'b0;
    logic sleep_req = 1'b0, rd_ack = 1'b0;
    logic rx_irq_en = 1'b0, idle_irq_en = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit8, data_full, overrun, idle_seen, noise_seen, frame_err, asleep, irq;
    logic [1:0] tdiv = 2'd0;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    // 16x strobe: one cycle in every four.
    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd2);
    end

    uart_wake_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_in(line_in),
        .rx_en(rx_en), .nine_bit(nine_bit), .wake_on_mark(wake_on_mark),
        .sleep_req(sleep_req), .rd_ack(rd_ack), .rx_irq_en(rx_irq_en),
        .idle_irq_en(idle_irq_en), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .data_full(data_full), .overrun(overrun), .idle_seen(idle_seen),
        .noise_seen(noise_seen), .frame_err(frame_err), .asleep(asleep), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_bits(input int n);
        wait_clk(n * BITCLK);
    endtask

    task automatic pulse_read();
        rd_ack = 1'b1; wait_clk(1); rd_ack = 1'b0; wait_clk(1);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; wait_clk(1); sleep_req = 1'b0; wait_clk(1);
    endtask

    // Send one character; glitch_bit >= 0 flips one sample-width in that data bit.
    task automatic send_char(input logic [8:0] v, input logic nine, input logic stop_v,
                             input int glitch_bit);
        line_in = 1'b0; wait_bits(1);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            line_in = v[i];
            if (i == glitch_bit) begin
                wait_clk(32); line_in = !v[i]; wait_clk(4); line_in = v[i]; wait_clk(28);
            end else begin
                wait_bits(1);
            end
        end
        line_in = stop_v; wait_bits(1);
        line_in = 1'b1;
    endtask

    function automatic logic [7:0] exp_byte(input logic [8:0] v);
        return v[7:0];
    endfunction

    function automatic logic exp_ninth(input logic [8:0] v, input logic nine);
        return nine & v[8];
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        wait_clk(5);
        @(negedge clk);
        check("R1 data_full", data_full, 0);
        check("R1 flags", {overrun, idle_seen, noise_seen, frame_err, asleep, irq, rx_bit8}, 0);
        check("R1 rx_data", rx_data, 0);
        wait_clk(1); rst_n = 1'b1; rx_en = 1'b1; wait_clk(4);

        // R7: no idle before any character has been framed
        wait_bits(13); @(negedge clk);
        check("R7 no idle before first char", idle_seen, 0);

        // R4: short low pulse is not a start bit
        line_in = 1'b0; wait_clk(16); line_in = 1'b1; wait_bits(12); @(negedge clk);
        check("R4 false start", data_full, 0);

        // R2: 8-bit character
        send_char(9'h0A5, 1'b0, 1'b1, -1); @(negedge clk);
        check("R2 data", rx_data, 8'hA5);
        check("R2 ninth zero", rx_bit8, 0);
        check("R2 full", data_full, 1);
        check("R5 good stop", frame_err, 0);
        check("R4 clean no noise", noise_seen, 0);

        // R10: interrupt gating on data_full
        rx_irq_en = 1'b1; wait_clk(1); @(negedge clk);
        check("R10 irq rx", irq, 1);
        rx_irq_en = 1'b0; wait_clk(1); @(negedge clk);
        check("R10 irq masked", irq, 0);

        // R6: overrun keeps older byte, read clears
        send_char(9'h03C, 1'b0, 1'b1, -1); @(negedge clk);
        check("R6 overrun", overrun, 1);
        check("R6 data kept", rx_data, 8'hA5);
        pulse_read(); @(negedge clk);
        check("R6 read clears", {data_full, overrun}, 0);

        // R7: idle after one character time, not early, not re-armed
        wait_bits(4); @(negedge clk);
        check("R7 idle not early", idle_seen, 0);
        idle_irq_en = 1'b1;
        wait_bits(10); @(negedge clk);
        check("R7 idle set", idle_seen, 1);
        check("R10 irq idle", irq, 1);
        idle_irq_en = 1'b0;
        pulse_read(); wait_bits(13); @(negedge clk);
        check("R7 idle not rearmed", idle_seen, 0);

        // R3: 9-bit character
        nine_bit = 1'b1;
        send_char(9'h15A, 1'b1, 1'b1, -1); @(negedge clk);
        check("R3 data", rx_data, 8'h5A);
        check("R3 ninth", rx_bit8, 1);
        pulse_read();

        // R4: one glitched sample keeps the value and sets noise
        nine_bit = 1'b0;
        send_char(9'h0F0, 1'b0, 1'b1, 2); @(negedge clk);
        check("R4 voted data", rx_data, 8'hF0);
        check("R4 noise", noise_seen, 1);
        pulse_read();

        // R5: stop bit low
        send_char(9'h081, 1'b0, 1'b0, -1); wait_bits(1); @(negedge clk);
        check("R5 frame error", frame_err, 1);
        check("R5 data", rx_data, 8'h81);
        pulse_read(); wait_bits(13); pulse_read();

        // R8: wake by address mark, 8-bit
        wake_on_mark = 1'b1; pulse_sleep(); @(negedge clk);
        check("R8 asleep", asleep, 1);
        send_char(9'h012, 1'b0, 1'b1, -1); @(negedge clk);
        check("R8 unmarked ignored", {data_full, rx_data}, {1'b0, 8'h81});
        check("R8 still asleep", asleep, 1);
        send_char(9'h09A, 1'b0, 1'b1, -1); @(negedge clk);
        check("R8 woke", asleep, 0);
        check("R8 mark delivered", {data_full, rx_data}, {1'b1, 8'h9A});
        pulse_read(); wait_bits(13); pulse_read();

        // R8: 9-bit mark is bit 8
        nine_bit = 1'b1; pulse_sleep();
        send_char(9'h0F0, 1'b1, 1'b1, -1); @(negedge clk);
        check("R8 9-bit bit7 no wake", {asleep, data_full}, 2'b10);
        send_char(9'h103, 1'b1, 1'b1, -1); @(negedge clk);
        check("R8 9-bit woke", {asleep, data_full, rx_bit8, rx_data}, {3'b011, 8'h03});
        pulse_read(); wait_bits(13); pulse_read();

        // R9: wake by idle line
        nine_bit = 1'b0; wake_on_mark = 1'b0; pulse_sleep();
        send_char(9'h055, 1'b0, 1'b1, -1); @(negedge clk);
        check("R9 asleep data ignored", {asleep, data_full}, 2'b10);
        wait_bits(13); @(negedge clk);
        check("R9 idle woke", asleep, 0);
        check("R9 idle flag quiet", idle_seen, 0);
        send_char(9'h03C, 1'b0, 1'b1, -1); @(negedge clk);
        check("R9 next delivered", {data_full, rx_data}, {1'b1, 8'h3C});
        pulse_read();

        // R11: disabled receiver ignores line; disable clears sleep
        rx_en = 1'b0;
        send_char(9'h0C3, 1'b0, 1'b1, -1); @(negedge clk);
        check("R11 disabled ignores", {data_full, rx_data}, {1'b0, 8'h3C});
        rx_en = 1'b1; wait_clk(2); pulse_sleep(); rx_en = 1'b0; wait_clk(2); @(negedge clk);
        check("R11 disable clears sleep", asleep, 0);
        rx_en = 1'b1; wait_clk(4);

        // R2/R3: random characters in both formats
        for (int k = 0; k < 30; k++) begin
            logic [8:0] v;
            logic nb;
            v  = 9'($urandom);
            nb = 1'($urandom);
            nine_bit = nb; wait_clk(2);
            send_char(v, nb, 1'b1, -1); @(negedge clk);
            check(nb ? "R3 random data" : "R2 random data", rx_data, exp_byte(v));
            check(nb ? "R3 random ninth" : "R2 random ninth", rx_bit8, exp_ninth(v, nb));
            pulse_read();
            if ($urandom % 4 == 0) wait_bits(2);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule